// File: doc/BRIEF.md
# External interrupt line converter

This block takes a bank of raw external interrupt pins and turns each one into a clean active-high level request for a downstream interrupt controller. For each line, software picks one of four sensing modes: high level, low level, rising edge or falling edge. Each pin passes through a two-flop synchronizer. The sensing logic then sets a per-line request latch. That latch stays set until software clears it by writing a one to the line's bit in the clear register. The output is the request with the line's mask bit removed.

A small 32-bit word-addressed register port is used for configuration and status. It has an address, a write strobe, write data and a combinational read-data bus. The latch records requests even while a line is masked. Software must therefore clear a line's request before it unmasks the line, or a stale request appears at once. A software-set register forces requests on selected lines, as if those pins had fired.

Top module: `eiu_conv`

## Requirements
- R1: During reset, the mask register (byte address 0x00) reads all ones. Every other register reads zero, and every `irq_o` bit is low.
- R2: The software decodes these byte addresses: 0x00 mask, 0x04 source select, 0x08 masked status, 0x0C raw status, 0x10 clear, 0x14 polarity, 0x18 edge select, 0x1C software request. Mask, source select, polarity, edge select and software request read back what was last written. The clear register always reads zero.
- R3: A line with polarity bit 1 and edge bit 0 latches a request while its pin is high. The matching `irq_o` bit rises on the third rising clock edge after the pin changes, and stays high after the pin drops, until it is cleared.
- R4: A line with polarity bit 0 and edge bit 0 latches a request while its pin is low.
- R5: A line with polarity bit 1 and edge bit 1 latches only on a low-to-high pin transition. A pin held high after a clear, or a falling pin, creates no new request.
- R6: A line with polarity bit 0 and edge bit 1 latches only on a high-to-low pin transition. A rising pin creates no new request.
- R7: A mask bit of 1 forces the line's `irq_o` bit low, but the line still latches its request. Raw status (0x0C) shows the request. Masked status (0x08) equals raw AND NOT mask and always matches `irq_o`. Clearing the mask bit presents a stale request at once.
- R8: Writing 1 to a bit of the clear register (0x10) drops that line's request on the next clock edge. Lines written with 0 keep their requests.
- R9: In level mode, a clear issued while the pin is still active leaves the request set.
- R10: A 1 in the software request register (0x1C) sets the line's request one clock after it is written. The request stays set through a clear for as long as that software bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Raw external interrupt pins, asynchronous |
| addr_i | input | 5 | Register byte address, word aligned |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | NUM_LINES | Register write data |
| rdata_o | output | NUM_LINES | Register read data, combinational from `addr_i` |
| irq_o | output | NUM_LINES | Active-high level request per line toward the parent controller |

## Verification
The four sensing modes run on separate lines, one mode per line. Each pin is driven both toward and away from its active state. This shows whether the design follows level or transition, and which polarity it honours. Clears are issued in three situations: while a level pin is still active, after an edge pin has stayed high, and on one line of a pair. These cases separate the clear's priority, the re-latch behaviour and the per-bit write-one action. A masked line is fired and then unmasked, and the software register is held set through a clear. These two cases show whether latching is independent of masking and whether a forced request persists.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  localparam int EIU_ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_SRC  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_RAW  = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_POL  = 3'd5,
    SEL_EDGE = 3'd6,
    SEL_SWI  = 3'd7
  } reg_sel_e;

  function automatic logic [EIU_ADDR_W-1:0] byte_addr(reg_sel_e s);
    return {s, 2'b00};
  endfunction
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eiu_sense.sv
module eiu_sense #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] edge_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q, act, act_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  // normalise both samples to active-high before comparing
  assign act      = ~(lvl_i  ^ pol_i);
  assign act_prev = ~(prev_q ^ pol_i);

  for (genvar i = 0; i < W; i++) begin : g_line
    assign hit_o[i] = edge_i[i] ? (act[i] & ~act_prev[i]) : act[i];
  end
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
  import eiu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [EIU_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [W-1:0]          req_i,
  output logic [W-1:0]          rdata_o,
  output logic [W-1:0]          mask_o,
  output logic [W-1:0]          pol_o,
  output logic [W-1:0]          edge_o,
  output logic [W-1:0]          swi_o,
  output logic [W-1:0]          clr_o
);
  logic     aligned, wr_hit;
  reg_sel_e sel;
  logic [W-1:0] mask_q, src_q, pol_q, edge_q, swi_q;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr_i[EIU_ADDR_W-1:2]);
  assign wr_hit  = wr_en_i & aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      src_q  <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      swi_q  <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_MASK: mask_q <= wdata_i;
        SEL_SRC:  src_q  <= wdata_i;
        SEL_POL:  pol_q  <= wdata_i;
        SEL_EDGE: edge_q <= wdata_i;
        SEL_SWI:  swi_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr_hit && sel == SEL_CLR) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (sel)
        SEL_MASK: rdata_o = mask_q;
        SEL_SRC:  rdata_o = src_q;
        SEL_STAT: rdata_o = req_i & ~mask_q;
        SEL_RAW:  rdata_o = req_i;
        SEL_POL:  rdata_o = pol_q;
        SEL_EDGE: rdata_o = edge_q;
        SEL_SWI:  rdata_o = swi_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign swi_o  = swi_q;
endmodule

// File: rtl/eiu_conv.sv
module eiu_conv
  import eiu_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  irq_i,
  input  logic [EIU_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [NUM_LINES-1:0]  wdata_i,
  output logic [NUM_LINES-1:0]  rdata_o,
  output logic [NUM_LINES-1:0]  irq_o
);
  logic [NUM_LINES-1:0] lvl_sync, hit, req_q, mask_q, pol_q, edge_q, swi_q, clr;

  eiu_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (lvl_sync)
  );

  eiu_sense #(.W(NUM_LINES)) u_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_sync),
    .pol_i (pol_q),
    .edge_i(edge_q),
    .hit_o (hit)
  );

  eiu_regs #(.W(NUM_LINES)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .req_i  (req_q),
    .rdata_o(rdata_o),
    .mask_o (mask_q),
    .pol_o  (pol_q),
    .edge_o (edge_q),
    .swi_o  (swi_q),
    .clr_o  (clr)
  );

  // set beats clear: an active level or forced line re-latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & ~clr) | hit | swi_q;
  end

  assign irq_o = req_q & ~mask_q;
endmodule

// File: rtl/eiu_conv_chk.sv
module eiu_conv_chk
  import eiu_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [EIU_ADDR_W-1:0] addr_i,
  input logic                  wr_en_i,
  input logic [NUM_LINES-1:0]  wdata_i,
  input logic [NUM_LINES-1:0]  rdata_o,
  input logic [NUM_LINES-1:0]  irq_o,
  input logic [NUM_LINES-1:0]  req_q,
  input logic [NUM_LINES-1:0]  mask_q,
  input logic [NUM_LINES-1:0]  swi_q
);
  logic [NUM_LINES-1:0] clr_v;
  logic                 mask_wr;
  assign clr_v   = (wr_en_i && addr_i == byte_addr(SEL_CLR)) ? wdata_i : '0;
  assign mask_wr = wr_en_i && addr_i == byte_addr(SEL_MASK);

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == byte_addr(SEL_CLR)) |-> (rdata_o == '0)); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mask_wr) |-> $stable(mask_q)); // R2
  AST_STATUS_IS_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == byte_addr(SEL_STAT)) |-> (rdata_o == irq_o)); // R7
  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(req_q) & ~$past(clr_v) & ~req_q) == '0)); // R8
  AST_SWI_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(swi_q) & ~req_q) == '0)); // R10
endmodule

bind eiu_conv eiu_conv_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .req_q  (req_q),
  .mask_q (mask_q),
  .swi_q  (swi_q)
);

// File: tb/sim_eiu_conv.sv
module sim_eiu_conv;
  localparam logic [4:0] A_MASK = 5'h00, A_SRC = 5'h04, A_STAT = 5'h08, A_RAW = 5'h0C,
                         A_CLR = 5'h10, A_POL = 5'h14, A_EDGE = 5'h18, A_SWI = 5'h1C;
  localparam logic [31:0] POL_CFG  = ~32'h0000_000A;
  localparam logic [31:0] EDGE_CFG = 32'h0000_000C;
  localparam logic [31:0] MASK_RUN = ~32'h0000_003F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = 32'h0000_000A;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq_out;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  eiu_conv u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic drive(int idx, logic v);
    @(negedge clk);
    irq[idx] = v;
  endtask

  task automatic t_reset;
    #1;
    rd_chk(A_MASK, 32'hFFFF_FFFF, "R1 mask");
    rd_chk(A_SRC,  32'h0, "R1 src");
    rd_chk(A_STAT, 32'h0, "R1 stat");
    rd_chk(A_RAW,  32'h0, "R1 raw");
    rd_chk(A_POL,  32'h0, "R1 pol");
    rd_chk(A_EDGE, 32'h0, "R1 edge");
    rd_chk(A_SWI,  32'h0, "R1 swi");
    chk("R1 irq_o", irq_out, 32'h0);
  endtask

  task automatic t_setup;
    wr(A_POL, POL_CFG);
    wr(A_EDGE, EDGE_CFG);
    wait_n(4);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd_chk(A_RAW, 32'h0, "R8 clear all");
    wr(A_MASK, MASK_RUN);
    wr(A_SRC, 32'hA5C3_0F69);
    rd_chk(A_SRC, 32'hA5C3_0F69, "R2 src readback");
    rd_chk(A_MASK, MASK_RUN, "R2 mask readback");
    rd_chk(A_POL, POL_CFG, "R2 pol readback");
    rd_chk(A_EDGE, EDGE_CFG, "R2 edge readback");
    rd_chk(A_CLR, 32'h0, "R2 clear reads zero");
    chk("R7 idle outputs", irq_out, 32'h0);
  endtask

  task automatic t_level_high;
    drive(0, 1'b1);
    wait_n(2);
    chk("R3 latency not yet", irq_out, 32'h0);
    wait_n(1);
    chk("R3 level high latched", irq_out, 32'h1);
    wr(A_CLR, 32'h1);
    chk("R9 clear while active", irq_out, 32'h1);
    drive(0, 1'b0);
    wait_n(3);
    chk("R3 held after pin drop", irq_out, 32'h1);
    wr(A_CLR, 32'h1);
    chk("R3 cleared", irq_out, 32'h0);
  endtask

  task automatic t_level_low;
    drive(1, 1'b0);
    wait_n(3);
    chk("R4 level low latched", irq_out, 32'h2);
    drive(1, 1'b1);
    wait_n(3);
    wr(A_CLR, 32'h2);
    chk("R4 cleared", irq_out, 32'h0);
  endtask

  task automatic t_edges;
    drive(2, 1'b1);
    wait_n(3);
    chk("R5 rising latched", irq_out, 32'h4);
    wr(A_CLR, 32'h4);
    wait_n(3);
    chk("R5 steady high no retrigger", irq_out, 32'h0);
    drive(2, 1'b0);
    wait_n(3);
    chk("R5 falling ignored", irq_out, 32'h0);
    drive(2, 1'b1);
    wait_n(3);
    drive(2, 1'b0);
    wait_n(3);
    chk("R5 second rise held", irq_out, 32'h4);
    drive(3, 1'b0);
    wait_n(3);
    chk("R6 falling latched", irq_out, 32'hC);
    wr(A_CLR, 32'h4);
    chk("R8 only written bit cleared", irq_out, 32'h8);
    wr(A_CLR, 32'h8);
    drive(3, 1'b1);
    wait_n(3);
    chk("R6 rising ignored", irq_out, 32'h0);
  endtask

  task automatic t_mask;
    wr(A_MASK, MASK_RUN | 32'h1);
    drive(0, 1'b1);
    wait_n(3);
    chk("R7 masked output low", irq_out, 32'h0);
    rd_chk(A_RAW, 32'h1, "R7 raw shows request");
    rd_chk(A_STAT, 32'h0, "R7 masked status");
    drive(0, 1'b0);
    wait_n(3);
    wr(A_MASK, MASK_RUN);
    chk("R7 stale on unmask", irq_out, 32'h1);
    rd_chk(A_STAT, 32'h1, "R7 status after unmask");
    wr(A_CLR, 32'h1);
    chk("R7 cleared", irq_out, 32'h0);
  endtask

  task automatic t_swi;
    wr(A_SWI, 32'h10);
    rd_chk(A_SWI, 32'h10, "R2 swi readback");
    wait_n(1);
    chk("R10 forced request", irq_out, 32'h10);
    wr(A_CLR, 32'h10);
    chk("R10 persists through clear", irq_out, 32'h10);
    wr(A_SWI, 32'h0);
    wr(A_CLR, 32'h10);
    chk("R10 released", irq_out, 32'h0);
    rd_chk(A_RAW, 32'h0, "R8 raw empty at end");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait_n(2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_setup();
    t_level_high();
    t_level_low();
    t_edges();
    t_mask();
    t_swi();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule